// File: doc/BRIEF.md
# Legacy Display Address Routing Decoder

This block sits on the processor's outbound request path. It decides, one request at a time, whether a transaction aimed at the legacy monochrome (MDA) or VGA display resources is claimed by the downstream graphics port or stays on the internal backbone. Each request is a memory or I/O access. It carries a dword address and four byte enables. Address bits [1:0] are implied zero, and byte lane i addresses byte `4*dword + i`.

The routing policy is set by four configuration bits: VGA enable, MDA present, memory access enable and I/O access enable. An I/O base/limit window is also supplied. The decision is made combinationally and captured in a three-state result register. `RT_IDLE` means no result. `RT_BACKBONE` means the request stays internal. `RT_GFX` means the request is claimed by the graphics port. The illegal-configuration flag is captured alongside the result.

The state transitions are as follows:
- Every cycle with `req_valid` high moves to `RT_GFX` or `RT_BACKBONE`, according to the decode.
- Every cycle without it returns to `RT_IDLE`.
- Back-to-back requests move directly between `RT_GFX` and `RT_BACKBONE`.
- Reset forces `RT_IDLE`.

Top module: `legdisp_router`

## Requirements
- R1: `route_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. Synchronous reset gives `route_valid=0`, `route_to_gfx=0` and `route_illegal=0`. `route_to_gfx` and `route_illegal` are 0 whenever `route_valid` is 0.
- R2: With VGA enable 0 and MDA present 0, no request is routed to the graphics port, and `route_illegal` is 0.
- R3: With VGA enable 0 and MDA present 1, `route_illegal` is 1 with the result, and nothing is routed to the graphics port.
- R4: With VGA enable 1 and MDA present 0, memory requests whose byte address lies in 0x0A0000–0x0BFFFF go to the graphics port. This range includes the MDA window.
- R5: With VGA enable 1 and MDA present 1, memory requests in 0x0B0000–0x0B7FFF stay on the backbone. The rest of 0x0A0000–0x0BFFFF goes to the graphics port.
- R6: A memory request is never routed to the graphics port while memory access enable is 0.
- R7: With VGA enable 1 and I/O access enable 1, an I/O request with an enabled byte on a VGA port (0x3B0–0x3BB or 0x3C0–0x3DF) goes to the graphics port, unless R9 or R10 applies. With I/O access enable 0, no I/O request is routed to the graphics port.
- R8: Byte address bits 15:10 are ignored when I/O ports are classified, so aliases such as 0xFFC0 behave like 0x3C0.
- R9: With both VGA enable and MDA present set, an I/O request stays on the backbone as a whole if any enabled byte falls on an MDA port (0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA, 0x3BF or an alias). With MDA present 0, these ports are routed like VGA ports.
- R10: With VGA enable 1 and MDA present 0, an I/O request with an enabled byte on ports 0x3BC–0x3BF goes to the graphics port only if I/O access enable is set and the full 16-bit dword byte address lies in [base, limit] inclusive.
- R11: Requests outside these ranges stay on the backbone. Memory decode compares all address bits, so 0x1A0000 does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_addr | input | ADDR_W-2 | Dword address (byte address bits ADDR_W-1:2) |
| req_be | input | 4 | Byte enables, lane i = byte 4*dword+i |
| cfg_vga_en | input | 1 | VGA enable |
| cfg_mda_present | input | 1 | MDA present |
| cfg_mem_en | input | 1 | Memory access enable |
| cfg_io_en | input | 1 | I/O access enable |
| cfg_io_base | input | IO_W | I/O window base (byte address) |
| cfg_io_limit | input | IO_W | I/O window limit (byte address, inclusive) |
| route_valid | output | 1 | Result valid |
| route_to_gfx | output | 1 | 1 = graphics port, 0 = backbone |
| route_illegal | output | 1 | Illegal configuration seen with this request |

## Verification
The bench uses the defaults ADDR_W=32 and IO_W=16. The 32-bit width gives room for memory addresses above 1 MiB, which must not mirror into the legacy window. The 16-bit I/O width exposes bits 15:10, so alias ports such as 0x07B4, 0x43C0 and 0xFFC0 can be driven. It also lets a window placed at 0x1000–0x1FFF include an alias of 0x3BC while excluding the port itself.

// File: rtl/legdisp_pkg.sv
package legdisp_pkg;

    localparam int LEG_PORT_W = 10;

    typedef enum logic [1:0] {
        RT_IDLE     = 2'd0,
        RT_BACKBONE = 2'd1,
        RT_GFX      = 2'd2
    } rt_state_e;

    // encoded as {vga enable, mda present}
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_BAD   = 2'b01,
        MODE_ALL   = 2'b10,
        MODE_SPLIT = 2'b11
    } mode_e;

    function automatic logic port_is_mda(input logic [LEG_PORT_W-1:0] p);
        return (p == 10'h3B4) || (p == 10'h3B5) || (p == 10'h3B8) ||
               (p == 10'h3B9) || (p == 10'h3BA) || (p == 10'h3BF);
    endfunction

    function automatic logic port_is_vga(input logic [LEG_PORT_W-1:0] p);
        return ((p >= 10'h3B0) && (p <= 10'h3BB)) ||
               ((p >= 10'h3C0) && (p <= 10'h3DF));
    endfunction

    function automatic logic port_is_tail(input logic [LEG_PORT_W-1:0] p);
        return (p >= 10'h3BC) && (p <= 10'h3BF);
    endfunction

endpackage

// File: rtl/legdisp_io_decode.sv
module legdisp_io_decode
    import legdisp_pkg::*;
#(
    parameter int IO_W = 16,
    parameter int BE_W = 4
) (
    input  logic [IO_W-1:$clog2(BE_W)] io_dw,
    input  logic [BE_W-1:0]            be,
    input  logic [IO_W-1:0]            win_base,
    input  logic [IO_W-1:0]            win_limit,
    output logic                       mda_hit,
    output logic                       vga_hit,
    output logic                       tail_hit,
    output logic                       in_win
);
    localparam int LANE_W = $clog2(BE_W);

    logic [BE_W-1:0] lane_mda;
    logic [BE_W-1:0] lane_vga;
    logic [BE_W-1:0] lane_tail;

    // one classifier per byte lane; upper port bits are dropped (aliasing)
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        logic [LEG_PORT_W-1:0] lane_port;
        assign lane_port    = {io_dw[LEG_PORT_W-1:LANE_W], LANE_W'(i)};
        assign lane_mda[i]  = be[i] && port_is_mda(lane_port);
        assign lane_vga[i]  = be[i] && port_is_vga(lane_port);
        assign lane_tail[i] = be[i] && port_is_tail(lane_port);
    end

    assign mda_hit  = |lane_mda;
    assign vga_hit  = |lane_vga;
    assign tail_hit = |lane_tail;

    logic [IO_W-1:0] io_byte;
    assign io_byte = {io_dw, {LANE_W{1'b0}}};
    assign in_win  = (io_byte >= win_base) && (io_byte <= win_limit);

endmodule

// File: rtl/legdisp_mem_decode.sv
module legdisp_mem_decode #(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:LANE_W] mem_dw,
    output logic                   mda_hit,
    output logic                   vga_hit
);
    localparam logic [ADDR_W-1:0] VGA_LO = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] VGA_HI = ADDR_W'(32'h000B_FFFF);
    localparam logic [ADDR_W-1:0] MDA_LO = ADDR_W'(32'h000B_0000);
    localparam logic [ADDR_W-1:0] MDA_HI = ADDR_W'(32'h000B_7FFF);

    logic [ADDR_W-1:0] mem_byte;
    assign mem_byte = {mem_dw, {LANE_W{1'b0}}};

    // full-width compare: no mirroring above the first megabyte
    assign vga_hit = (mem_byte >= VGA_LO) && (mem_byte <= VGA_HI);
    assign mda_hit = (mem_byte >= MDA_LO) && (mem_byte <= MDA_HI);

endmodule

// File: rtl/legdisp_policy.sv
module legdisp_policy
    import legdisp_pkg::*;
(
    input  logic vga_en,
    input  logic mda_present,
    input  logic is_io,
    input  logic mem_en,
    input  logic io_en,
    input  logic io_mda,
    input  logic io_vga,
    input  logic io_tail,
    input  logic io_in_win,
    input  logic mem_mda,
    input  logic mem_vga,
    output logic to_gfx,
    output logic illegal
);
    mode_e mode;
    assign mode = mode_e'({vga_en, mda_present});

    always_comb begin
        to_gfx  = 1'b0;
        illegal = 1'b0;
        unique case (mode)
            MODE_OFF: to_gfx = 1'b0;
            MODE_BAD: begin
                illegal = 1'b1;
                to_gfx  = 1'b0;
            end
            MODE_ALL: begin
                if (is_io) begin
                    if (io_tail)
                        to_gfx = io_en && io_in_win;
                    else
                        to_gfx = io_en && (io_vga || io_mda);
                end else begin
                    to_gfx = mem_en && mem_vga;
                end
            end
            MODE_SPLIT: begin
                if (is_io)
                    to_gfx = io_en && io_vga && !io_mda;
                else
                    to_gfx = mem_en && mem_vga && !mem_mda;
            end
            default: to_gfx = 1'b0;
        endcase
    end

endmodule

// File: rtl/legdisp_router.sv
module legdisp_router
    import legdisp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic [ADDR_W-3:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic              cfg_vga_en,
    input  logic              cfg_mda_present,
    input  logic              cfg_mem_en,
    input  logic              cfg_io_en,
    input  logic [IO_W-1:0]   cfg_io_base,
    input  logic [IO_W-1:0]   cfg_io_limit,
    output logic              route_valid,
    output logic              route_to_gfx,
    output logic              route_illegal
);
    localparam int BE_W   = 4;
    localparam int LANE_W = $clog2(BE_W);

    logic io_mda, io_vga, io_tail, io_in_win;
    logic mem_mda, mem_vga;
    logic gfx_d, illegal_d;

    legdisp_io_decode #(.IO_W(IO_W), .BE_W(BE_W)) u_io (
        .io_dw    (req_addr[IO_W-LANE_W-1:0]),
        .be       (req_be),
        .win_base (cfg_io_base),
        .win_limit(cfg_io_limit),
        .mda_hit  (io_mda),
        .vga_hit  (io_vga),
        .tail_hit (io_tail),
        .in_win   (io_in_win)
    );

    legdisp_mem_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
        .mem_dw (req_addr),
        .mda_hit(mem_mda),
        .vga_hit(mem_vga)
    );

    legdisp_policy u_pol (
        .vga_en     (cfg_vga_en),
        .mda_present(cfg_mda_present),
        .is_io      (req_is_io),
        .mem_en     (cfg_mem_en),
        .io_en      (cfg_io_en),
        .io_mda     (io_mda),
        .io_vga     (io_vga),
        .io_tail    (io_tail),
        .io_in_win  (io_in_win),
        .mem_mda    (mem_mda),
        .mem_vga    (mem_vga),
        .to_gfx     (gfx_d),
        .illegal    (illegal_d)
    );

    rt_state_e state, state_nx;
    logic      illegal_q;

    always_comb begin
        state_nx = RT_IDLE;
        if (req_valid)
            state_nx = gfx_d ? RT_GFX : RT_BACKBONE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RT_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= req_valid && illegal_d;
    end

    always_comb begin
        route_valid  = 1'b0;
        route_to_gfx = 1'b0;
        unique case (state)
            RT_IDLE: begin
                route_valid  = 1'b0;
                route_to_gfx = 1'b0;
            end
            RT_BACKBONE: begin
                route_valid  = 1'b1;
                route_to_gfx = 1'b0;
            end
            RT_GFX: begin
                route_valid  = 1'b1;
                route_to_gfx = 1'b1;
            end
            default: begin
                route_valid  = 1'b0;
                route_to_gfx = 1'b0;
            end
        endcase
    end
    assign route_illegal = illegal_q;

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> route_valid); // R1
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!route_valid && !route_to_gfx && !route_illegal)); // R1
    AST_ILLEGAL_CLAIMS_NOTHING: assert property (@(posedge clk) disable iff (rst)
        route_illegal |-> !route_to_gfx); // R3
    AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_io && !cfg_mem_en) |=> !route_to_gfx); // R6
    AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && !cfg_io_en) |=> !route_to_gfx); // R7
    AST_MDA_PORT_STAYS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && cfg_vga_en && cfg_mda_present && io_mda)
        |=> !route_to_gfx); // R9
    AST_MDA_MEM_STAYS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_io && cfg_vga_en && cfg_mda_present && mem_mda)
        |=> !route_to_gfx); // R5

endmodule

// File: tb/sim_legdisp_router.sv
module sim_legdisp_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_io;
    logic [29:0] req_addr;
    logic [3:0]  req_be;
    logic        cfg_vga_en, cfg_mda_present, cfg_mem_en, cfg_io_en;
    logic [15:0] cfg_io_base, cfg_io_limit;
    logic        route_valid, route_to_gfx, route_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    legdisp_router #(.ADDR_W(32), .IO_W(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .req_be(req_be), .cfg_vga_en(cfg_vga_en),
        .cfg_mda_present(cfg_mda_present), .cfg_mem_en(cfg_mem_en),
        .cfg_io_en(cfg_io_en), .cfg_io_base(cfg_io_base),
        .cfg_io_limit(cfg_io_limit), .route_valid(route_valid),
        .route_to_gfx(route_to_gfx), .route_illegal(route_illegal)
    );

    task automatic check3(input string tag, input logic v, input logic g, input logic il);
        n_checks++;
        if (route_valid !== v || route_to_gfx !== g || route_illegal !== il) begin
            n_fail++;
            $display("FAIL %s: actual valid/gfx/illegal=%b%b%b expected=%b%b%b",
                     tag, route_valid, route_to_gfx, route_illegal, v, g, il);
        end
    endtask

    task automatic set_cfg(input logic v, input logic m, input logic me, input logic ie,
                           input logic [15:0] b, input logic [15:0] l);
        cfg_vga_en = v; cfg_mda_present = m; cfg_mem_en = me; cfg_io_en = ie;
        cfg_io_base = b; cfg_io_limit = l;
    endtask

    // drive at a falling edge, result is registered on the next rising edge,
    // sampled at the falling edge after it
    task automatic send(input string tag, input logic io, input logic [31:0] a,
                        input logic [3:0] be, input logic exp_g, input logic exp_il);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_addr = a[31:2]; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        check3(tag, 1'b1, exp_g, exp_il);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check3("R1 reset state", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_timing;
        set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = 1'b0; req_addr = 30'h0002_8000; req_be = 4'hF;
        @(negedge clk);
        check3("R1 first of pair", 1'b1, 1'b1, 1'b0);
        req_addr = 30'h0003_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check3("R1 second of pair", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check3("R1 idle after gap", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mode_off;
        set_cfg(0, 0, 1, 1, 16'h0000, 16'hFFFF);
        send("R2 mem A0000", 0, 32'h000A_0000, 4'hF, 0, 0);
        send("R2 io 3C0", 1, 32'h0000_03C0, 4'h1, 0, 0);
    endtask

    task automatic t_mode_bad;
        set_cfg(0, 1, 1, 1, 16'h0000, 16'hFFFF);
        send("R3 illegal mem", 0, 32'h000A_0000, 4'hF, 0, 1);
        send("R3 illegal io", 1, 32'h0000_03C0, 4'h1, 0, 1);
    endtask

    task automatic t_mem_all;
        set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
        send("R4 A0000", 0, 32'h000A_0000, 4'hF, 1, 0);
        send("R4 BFFFC", 0, 32'h000B_FFFC, 4'hF, 1, 0);
        send("R4 MDA B0000", 0, 32'h000B_0000, 4'hF, 1, 0);
    endtask

    task automatic t_mem_split;
        set_cfg(1, 1, 1, 1, 16'h0000, 16'hFFFF);
        send("R5 B0000", 0, 32'h000B_0000, 4'hF, 0, 0);
        send("R5 B7FFC", 0, 32'h000B_7FFC, 4'hF, 0, 0);
        send("R5 B8000", 0, 32'h000B_8000, 4'hF, 1, 0);
        send("R5 AFFFC", 0, 32'h000A_FFFC, 4'hF, 1, 0);
    endtask

    task automatic t_mem_gate;
        set_cfg(1, 0, 0, 1, 16'h0000, 16'hFFFF);
        send("R6 mem disabled", 0, 32'h000A_0000, 4'hF, 0, 0);
    endtask

    task automatic t_io_vga;
        set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
        send("R7 io 3C0", 1, 32'h0000_03C0, 4'h1, 1, 0);
        send("R7 io 3DF lane3", 1, 32'h0000_03DC, 4'h8, 1, 0);
        send("R9 mda port forwarded when absent", 1, 32'h0000_03B4, 4'h1, 1, 0);
        set_cfg(1, 0, 1, 0, 16'h0000, 16'hFFFF);
        send("R7 io disabled", 1, 32'h0000_03C0, 4'h1, 0, 0);
    endtask

    task automatic t_alias;
        set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
        send("R8 alias FFC0", 1, 32'h0000_FFC0, 4'h1, 1, 0);
        set_cfg(1, 1, 1, 1, 16'h0000, 16'hFFFF);
        send("R8 alias 07B4 mda", 1, 32'h0000_07B4, 4'h1, 0, 0);
        send("R8 alias 43C0 vga", 1, 32'h0000_43C0, 4'h1, 1, 0);
    endtask

    task automatic t_mda_bytes;
        set_cfg(1, 1, 1, 1, 16'h0000, 16'hFFFF);
        send("R9 3B4 lane0", 1, 32'h0000_03B4, 4'h1, 0, 0);
        send("R9 3B6 lane2", 1, 32'h0000_03B4, 4'h4, 1, 0);
        send("R9 mixed 3B5+3B6", 1, 32'h0000_03B4, 4'h6, 0, 0);
        send("R9 3B0+3B1", 1, 32'h0000_03B0, 4'h3, 1, 0);
        send("R9 3BB lane3", 1, 32'h0000_03B8, 4'h8, 1, 0);
        send("R9 3BF lane3", 1, 32'h0000_03BC, 4'h8, 0, 0);
    endtask

    task automatic t_tail_window;
        set_cfg(1, 0, 1, 1, 16'h0300, 16'h03FF);
        send("R10 3BC inside", 1, 32'h0000_03BC, 4'h1, 1, 0);
        set_cfg(1, 0, 1, 1, 16'h1000, 16'h1FFF);
        send("R10 3BC outside", 1, 32'h0000_03BC, 4'h1, 0, 0);
        send("R10 13BC alias inside", 1, 32'h0000_13BC, 4'h8, 1, 0);
        set_cfg(1, 0, 1, 0, 16'h1000, 16'h1FFF);
        send("R10 inside io disabled", 1, 32'h0000_13BC, 4'h1, 0, 0);
    endtask

    task automatic t_outside;
        set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
        send("R11 mem C0000", 0, 32'h000C_0000, 4'hF, 0, 0);
        send("R11 mem 1A0000", 0, 32'h001A_0000, 4'hF, 0, 0);
        send("R11 io 3E0", 1, 32'h0000_03E0, 4'h1, 0, 0);
        send("R11 io no bytes", 1, 32'h0000_03C0, 4'h0, 0, 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0; req_be = '0;
        set_cfg(0, 0, 0, 0, 16'h0000, 16'h0000);
        t_reset();
        t_timing();
        t_mode_off();
        t_mode_bad();
        t_mem_all();
        t_mem_split();
        t_mem_gate();
        t_io_vga();
        t_alias();
        t_mda_bytes();
        t_tail_window();
        t_outside();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule